// File: doc/BRIEF.md
# Pad Isolation Clamp Sequencer with Use Counting

This block drives the three isolation controls of an I/O pad power domain: a core-down flag, an early clamp and a final clamp. Several clients share the domain. Each client sends a one-cycle enable pulse when it needs the pads and a one-cycle disable pulse when it is finished. The block keeps a count of active users. Only the enable that takes the count from zero to one powers the domain up. Only the disable that brings the count back to zero powers it down. All other requests just change the count.

Both power sequences step the three controls in a fixed order. The gap between steps is a whole number of microsecond ticks, taken from a tick input. While a sequence runs, the busy output is high. A request that arrives during that time is held in a one-deep slot and served once the sequence ends. An error pulse flags three cases: a disable with no user left, an enable at the count ceiling, and a request lost because the slot was already full. A force-off input releases every user at once. The three controls also overwrite the top three bits of a control word that passes through the block.

Top module: `pad_clamp_seq`

## Requirements
- R1: After reset, core_down, clamp_early and clamp_final are all 1, use_count is 0, and busy and err_pulse are 0.
- R2: When an enable is served at count 0, use_count becomes 1 and the controls step from isolated to active in a fixed order: clamp_final falls first, then clamp_early, then core_down. Busy stays high from the first step until core_down falls.
- R3: Each step after the first comes exactly GAP_US tick_us pulses after the previous step. A tick is counted at every clock edge where tick_us is 1, up to and including the edge that makes the step. No control changes between steps.
- R4: An enable served at a nonzero count, below the ceiling, adds one to use_count and leaves all three controls unchanged.
- R5: A disable served at a count of 2 or more subtracts one and leaves all three controls unchanged.
- R6: A disable served at count 1 sets use_count to 0 and steps the controls in reverse order: core_down rises first, then clamp_early, then clamp_final. The same gap rule as R3 applies.
- R7: A disable served at count 0 gives a one-cycle err_pulse and changes neither the count nor the controls.
- R8: word_out carries core_down at bit WORD_W-1, clamp_early at bit WORD_W-2 and clamp_final at bit WORD_W-3. Every lower bit is copied from word_in.
- R9: While busy, the first request is held and served in the cycle after the sequence ends. If a new request arrives in that same cycle, the held request is served first and the new one takes the freed slot.
- R10: A request that arrives while busy, with the slot already full, is dropped and gives a one-cycle err_pulse.
- R11: An enable served at use_count = 2^CNT_W-1 gives err_pulse and leaves the count unchanged; it does not wrap to zero.
- R12: A force-off served at a nonzero count sets use_count to 0 and runs the power-down sequence of R6. At count 0 it does nothing and gives no error.
- R13: An enable and a disable pulse in the same cycle, without force-off, cancel each other: no change and no error. Force-off in the same cycle as either takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| en_req | input | 1 | Enable request pulse (one more user) |
| dis_req | input | 1 | Disable request pulse (one user fewer) |
| off_req | input | 1 | Force-off pulse (release every user) |
| word_in | input | WORD_W | Control word; bits below WORD_W-3 pass through |
| word_out | output | WORD_W | Control word with the three controls in its top bits |
| core_down | output | 1 | Core domain marked down (1 = down) |
| clamp_early | output | 1 | Early isolation clamp enable |
| clamp_final | output | 1 | Final isolation clamp enable |
| busy | output | 1 | A power sequence is in progress |
| err_pulse | output | 1 | One-cycle error flag |
| use_count | output | CNT_W | Current number of users |

## Verification
The case that matters most is when a held request is served in the same cycle as a new request arrives. This cycle comes right after the final step of a sequence. The bench first fills the slot with a disable during power-up. It then drives an enable at the first sample point where busy reads low. This makes the held disable start power-down while the enable takes the freed slot. A scoreboard of expected control patterns and tick gaps, with no error pulse allowed, must then see up, down and up again, ending with a count of one.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // request kind handed from the request slot to the sequencer
  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_ON    = 2'd1,
    REQ_OFF   = 2'd2,
    REQ_FORCE = 2'd3
  } req_e;

  // sequencer phases: A waits before the middle step, B before the last
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_UP_A = 3'd1,
    ST_UP_B = 3'd2,
    ST_DN_A = 3'd3,
    ST_DN_B = 3'd4
  } phase_e;

endpackage

// File: rtl/pcs_req_slot.sv
module pcs_req_slot
  import pcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic dis_req,
  input  logic off_req,
  input  logic seq_run,
  output req_e serve,
  output logic drop_err
);

  req_e in_kind;
  req_e held_q;
  logic held_v;

  // force wins; enable and disable together cancel
  always_comb begin
    if (off_req)               in_kind = REQ_FORCE;
    else if (en_req && !dis_req) in_kind = REQ_ON;
    else if (dis_req && !en_req) in_kind = REQ_OFF;
    else                       in_kind = REQ_NONE;
  end

  always_comb begin
    serve    = REQ_NONE;
    drop_err = 1'b0;
    if (!seq_run) begin
      serve = held_v ? held_q : in_kind;
    end else if (in_kind != REQ_NONE && held_v) begin
      drop_err = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_v <= 1'b0;
      held_q <= REQ_NONE;
    end else if (!seq_run) begin
      // held request (if any) is served now; a new arrival takes the slot
      if (held_v) begin
        held_v <= (in_kind != REQ_NONE);
        held_q <= in_kind;
      end
    end else if (!held_v && in_kind != REQ_NONE) begin
      held_v <= 1'b1;
      held_q <= in_kind;
    end
  end

endmodule

// File: rtl/pcs_gap_timer.sv
module pcs_gap_timer #(
  parameter int GAP_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick,
  output logic done
);

  localparam int TW = (GAP_US > 1) ? $clog2(GAP_US) : 1;
  localparam logic [TW-1:0] LAST = TW'(GAP_US - 1);

  logic [TW-1:0] ticks_q;

  assign done = tick && !clear && (ticks_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ticks_q <= '0;
    else if (clear || done)  ticks_q <= '0;
    else if (tick)           ticks_q <= ticks_q + TW'(1);
  end

endmodule

// File: rtl/pcs_step_fsm.sv
module pcs_step_fsm
  import pcs_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  req_e             serve,
  input  logic             drop_err,
  input  logic             gap_done,
  output logic             seq_run,
  output logic             core_q,
  output logic             early_q,
  output logic             final_q,
  output logic             err_q,
  output logic [CNT_W-1:0] users_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  phase_e           phase_q;
  logic [CNT_W-1:0] users_d;
  logic             go_up;
  logic             go_dn;
  logic             req_err;

  assign seq_run = (phase_q != ST_IDLE);

  // count decision for the request served this cycle
  always_comb begin
    users_d = users_q;
    go_up   = 1'b0;
    go_dn   = 1'b0;
    req_err = 1'b0;
    unique case (serve)
      REQ_ON: begin
        if (users_q == CNT_MAX) req_err = 1'b1;
        else begin
          users_d = users_q + CNT_ONE;
          go_up   = (users_q == '0);
        end
      end
      REQ_OFF: begin
        if (users_q == '0) req_err = 1'b1;
        else begin
          users_d = users_q - CNT_ONE;
          go_dn   = (users_q == CNT_ONE);
        end
      end
      REQ_FORCE: begin
        if (users_q != '0) begin
          users_d = '0;
          go_dn   = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= ST_IDLE;
      core_q  <= 1'b1;
      early_q <= 1'b1;
      final_q <= 1'b1;
      users_q <= '0;
      err_q   <= 1'b0;
    end else begin
      users_q <= users_d;
      err_q   <= req_err | drop_err;
      unique case (phase_q)
        ST_IDLE: begin
          if (go_up) begin
            final_q <= 1'b0;
            phase_q <= ST_UP_A;
          end else if (go_dn) begin
            core_q  <= 1'b1;
            phase_q <= ST_DN_A;
          end
        end
        ST_UP_A: if (gap_done) begin
          early_q <= 1'b0;
          phase_q <= ST_UP_B;
        end
        ST_UP_B: if (gap_done) begin
          core_q  <= 1'b0;
          phase_q <= ST_IDLE;
        end
        ST_DN_A: if (gap_done) begin
          early_q <= 1'b1;
          phase_q <= ST_DN_B;
        end
        ST_DN_B: if (gap_done) begin
          final_q <= 1'b1;
          phase_q <= ST_IDLE;
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pad_clamp_seq.sv
module pad_clamp_seq
  import pcs_pkg::*;
#(
  parameter int GAP_US = 100,
  parameter int CNT_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              en_req,
  input  logic              dis_req,
  input  logic              off_req,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] word_out,
  output logic              core_down,
  output logic              clamp_early,
  output logic              clamp_final,
  output logic              busy,
  output logic              err_pulse,
  output logic [CNT_W-1:0]  use_count
);

  localparam int KEEP_W = WORD_W - 3;

  req_e serve;
  logic drop_err;
  logic seq_run;
  logic gap_done;

  pcs_req_slot u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (en_req),
    .dis_req  (dis_req),
    .off_req  (off_req),
    .seq_run  (seq_run),
    .serve    (serve),
    .drop_err (drop_err)
  );

  pcs_gap_timer #(.GAP_US(GAP_US)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (!seq_run),
    .tick  (tick_us),
    .done  (gap_done)
  );

  pcs_step_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .serve    (serve),
    .drop_err (drop_err),
    .gap_done (gap_done),
    .seq_run  (seq_run),
    .core_q   (core_down),
    .early_q  (clamp_early),
    .final_q  (clamp_final),
    .err_q    (err_pulse),
    .users_q  (use_count)
  );

  assign busy     = seq_run;
  assign word_out = {core_down, clamp_early, clamp_final, word_in[KEEP_W-1:0]};

endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_us,
  input logic             core_down,
  input logic             clamp_early,
  input logic             clamp_final,
  input logic             busy,
  input logic [CNT_W-1:0] use_count
);

  logic [2:0] ctl;
  assign ctl = {core_down, clamp_early, clamp_final};

  // R2: release order final -> early -> core
  assert_up_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clamp_early) |-> !clamp_final);
  assert_up_core_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_down) |-> !clamp_early && !clamp_final);

  // R6: assert order core -> early -> final
  assert_dn_early_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_early) |-> core_down);
  assert_dn_final_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clamp_final) |-> core_down && clamp_early);

  // R3: inside a sequence, nothing moves on an edge without a tick
  assert_hold_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(tick_us)) |-> $stable(ctl));

  // R5: idle with users before and after means the controls stay put
  assert_quiet_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $past(use_count) != '0 && use_count != '0)
      |-> $stable(ctl));

endmodule

bind pad_clamp_seq pcs_checker #(.CNT_W(CNT_W)) u_pcs_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_us     (tick_us),
  .core_down   (core_down),
  .clamp_early (clamp_early),
  .clamp_final (clamp_final),
  .busy        (busy),
  .use_count   (use_count)
);

// File: tb/tb_pad_clamp_seq.sv
module tb_pad_clamp_seq;

  localparam int CLK_PERIOD = 10;
  localparam int GAP_US     = 100;
  localparam int CNT_W      = 4;
  localparam int WORD_W     = 32;
  localparam int TICK_DIV   = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick_us = 1'b0;
  logic              en_req = 1'b0;
  logic              dis_req = 1'b0;
  logic              off_req = 1'b0;
  logic [WORD_W-1:0] word_in = '0;
  logic [WORD_W-1:0] word_out;
  logic              core_down, clamp_early, clamp_final, busy, err_pulse;
  logic [CNT_W-1:0]  use_count;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [2:0] exp_ctl[$];
  int         exp_gap[$];
  logic [2:0] prev_ctl = 3'b111;
  int         tick_cnt = 0;
  int         div = 0;

  pad_clamp_seq #(.GAP_US(GAP_US), .CNT_W(CNT_W), .WORD_W(WORD_W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .en_req(en_req),
    .dis_req(dis_req), .off_req(off_req), .word_in(word_in),
    .word_out(word_out), .core_down(core_down), .clamp_early(clamp_early),
    .clamp_final(clamp_final), .busy(busy), .err_pulse(err_pulse),
    .use_count(use_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // microsecond tick, driven away from the active edge
  always @(negedge clk) begin
    div     = (div == TICK_DIV - 1) ? 0 : div + 1;
    tick_us = (div == 0);
  end

  always @(posedge clk) if (tick_us) tick_cnt++;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard monitor: every control change must match the next expected item
  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] cur;
      cur = {core_down, clamp_early, clamp_final};
      if (cur != prev_ctl) begin
        if (exp_ctl.size() == 0) begin
          check("R4/R5 unexpected control change", int'(cur), int'(prev_ctl));
        end else begin
          logic [2:0] e;
          int g;
          e = exp_ctl.pop_front();
          g = exp_gap.pop_front();
          check("R2/R6 control pattern", int'(cur), int'(e));
          if (g >= 0) check("R3 step gap in ticks", tick_cnt, g);
        end
        tick_cnt = 0;
        prev_ctl = cur;
      end
    end
  end

  task automatic push_up();
    exp_ctl.push_back(3'b110); exp_gap.push_back(-1);
    exp_ctl.push_back(3'b100); exp_gap.push_back(GAP_US);
    exp_ctl.push_back(3'b000); exp_gap.push_back(GAP_US);
  endtask

  task automatic push_dn();
    exp_ctl.push_back(3'b100); exp_gap.push_back(-1);
    exp_ctl.push_back(3'b110); exp_gap.push_back(GAP_US);
    exp_ctl.push_back(3'b111); exp_gap.push_back(GAP_US);
  endtask

  task automatic pulse(input bit e, input bit d, input bit f);
    en_req = e; dis_req = d; off_req = f;
    @(negedge clk);
    en_req = 0; dis_req = 0; off_req = 0;
  endtask

  task automatic wait_ctl(input logic [2:0] v);
    while ({core_down, clamp_early, clamp_final} != v) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    word_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 controls", int'({core_down, clamp_early, clamp_final}), 7);
    check("R1 count", int'(use_count), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 err", int'(err_pulse), 0);
    check("R8 word isolated", int'(word_out), int'({3'b111, word_in[28:0]}));

    // R2 first enable powers up
    push_up();
    pulse(1, 0, 0);
    check("R2 count", int'(use_count), 1);
    check("R2 busy", int'(busy), 1);
    wait_ctl(3'b000);
    check("R2 busy end", int'(busy), 0);

    // R4 more enables only count
    pulse(1, 0, 0);
    pulse(1, 0, 0);
    check("R4 count", int'(use_count), 3);
    check("R4 busy", int'(busy), 0);

    // R8 pass-through with domain up
    word_in = 32'hFFFF_FFFF; #1;
    check("R8 word ones", int'(word_out), int'(32'h1FFF_FFFF));
    word_in = 32'h0000_0000; #1;
    check("R8 word zero", int'(word_out), 0);

    // R5 non-final disables
    pulse(0, 1, 0);
    check("R5 count", int'(use_count), 2);
    pulse(0, 1, 0);
    check("R5 count", int'(use_count), 1);
    check("R5 controls", int'({core_down, clamp_early, clamp_final}), 0);

    // R6 last disable powers down
    push_dn();
    pulse(0, 1, 0);
    check("R6 count", int'(use_count), 0);
    check("R6 busy", int'(busy), 1);
    wait_ctl(3'b111);

    // R7 unbalanced disable
    @(negedge clk);
    pulse(0, 1, 0);
    check("R7 err", int'(err_pulse), 1);
    check("R7 count", int'(use_count), 0);
    check("R7 busy", int'(busy), 0);
    @(negedge clk);
    check("R7 err one cycle", int'(err_pulse), 0);

    // R13 enable+disable together cancel
    pulse(1, 1, 0);
    check("R13 count", int'(use_count), 0);
    check("R13 err", int'(err_pulse), 0);
    check("R13 busy", int'(busy), 0);

    // R12 force at zero does nothing
    pulse(0, 0, 1);
    check("R12 count zero", int'(use_count), 0);
    check("R12 no err", int'(err_pulse), 0);
    check("R12 no seq", int'(busy), 0);

    // R9/R10 queue during power-up, overflow dropped
    push_up();
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    check("R9 held not served", int'(use_count), 1);
    check("R9 no err on hold", int'(err_pulse), 0);
    pulse(0, 1, 0);
    check("R10 drop err", int'(err_pulse), 1);
    check("R10 count", int'(use_count), 1);
    push_dn();
    wait_ctl(3'b000);
    check("R9 idle gap cycle", int'(busy), 0);
    @(negedge clk);
    check("R9 held disable served", int'(use_count), 0);
    check("R9 power-down started", int'(busy), 1);
    wait_ctl(3'b111);
    @(negedge clk);
    check("R10 dropped stays dropped", int'(use_count), 0);
    check("R10 idle", int'(busy), 0);

    // R9 same cycle: held disable served while a new enable arrives
    push_up();
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    push_dn();
    push_up();
    wait_ctl(3'b000);
    pulse(1, 0, 0);
    check("R9 same-cycle held first", int'(use_count), 0);
    check("R9 same-cycle busy", int'(busy), 1);
    check("R9 same-cycle no err", int'(err_pulse), 0);
    wait_ctl(3'b111);
    @(negedge clk);
    check("R9 new enable served", int'(use_count), 1);
    check("R9 power-up again", int'(busy), 1);
    wait_ctl(3'b000);
    @(negedge clk);
    check("R9 final count", int'(use_count), 1);

    // R11 saturation
    for (int i = 0; i < 14; i++) pulse(1, 0, 0);
    check("R11 at ceiling", int'(use_count), 15);
    check("R11 no err yet", int'(err_pulse), 0);
    pulse(1, 0, 0);
    check("R11 err", int'(err_pulse), 1);
    check("R11 no wrap", int'(use_count), 15);

    // R12 force-off from ceiling
    push_dn();
    pulse(0, 0, 1);
    check("R12 count cleared", int'(use_count), 0);
    check("R12 power-down", int'(busy), 1);
    wait_ctl(3'b111);
    @(negedge clk);
    check("R12 idle", int'(busy), 0);

    repeat (20) @(negedge clk);
    check("R2/R6 scoreboard drained", exp_ctl.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule